// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block produces one of four pixel clock waveforms from a master clock: the master rate itself, half of it, a third of it, or a non-integer two-thirds of it. The block is clocked by a reference clock that runs at twice the master frequency. Each reference tick is therefore one half-cycle (one phase) of the master clock. Because both master phases are visible as states of a plain synchronous counter, the fractional rate can be built without gating or mixing clocks.

A three-bit state counter walks through a window whose length depends on the selected rate. The pixel waveform is decoded from the counter value, and in the fractional mode that value stands for both the master cycle and its phase. Two single-tick strobes come with the waveform. The first marks the start of each pixel period, so downstream logic can align to it. The second marks the last tick of each window. The rate select is sampled only at the end of a window, so switching rates never truncates a pulse. All three outputs are registered and follow the counter state by one reference tick.

Top module: `pixclk_divider`

## Requirements
- R1: While `rst` is high, `pixClk`, `periodStart` and `windowEnd` are 0. The counter is held at state 0 and the active rate is divide-by-1 (code 00).
- R2: With rate code 00 (divide-by-1), the window is 2 ticks long and `pixClk` alternates high for one tick and low for one tick.
- R3: With rate code 01 (divide-by-2), the window is 4 ticks long, with `pixClk` high for 2 ticks and then low for 2 ticks.
- R4: With rate code 10 (divide-by-3), the window is 6 ticks long, with `pixClk` high for 3 ticks and then low for 3 ticks.
- R5: With rate code 11 (two-thirds rate), the window is 6 ticks long. `pixClk` is high only in window ticks 0 and 3. It therefore changes level exactly four times per window and gives two periods of 3 ticks each at a 1/3 duty cycle.
- R6: `rateSel` is sampled only on the last tick of a window. A change at any other time leaves the waveform of the current window unchanged.
- R7: `periodStart` is high for exactly the ticks in which a pixel period begins: window tick 0 in every mode, and also window tick 3 in the two-thirds mode. It is high only while `pixClk` is high.
- R8: `windowEnd` is high on the last tick of each window. On that tick `pixClk` is low, and the next tick begins a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock at twice the master clock rate |
| rst | input | 1 | Synchronous active-high reset |
| rateSel | input | 2 | Rate code: 00 /1, 01 /2, 10 /3, 11 two-thirds |
| pixClk | output | 1 | Registered pixel clock waveform |
| periodStart | output | 1 | One-tick strobe at the start of each pixel period |
| windowEnd | output | 1 | One-tick strobe on the last tick of each window |

## Verification
The assertions assume that `rateSel` is settled at every rising edge of the reference clock. They also assume that reset is held for at least one edge, so that the counter and mode start from known values. The bench changes `rateSel` only on falling edges. It mixes random codes, which often change in the middle of a window, with long directed holds in each mode, so that both the hold-until-window-end rule and every steady waveform are exercised.

// File: rtl/pixdiv_pkg.sv
package pixdiv_pkg;
  typedef enum logic [1:0] {
    RATE_DIV1 = 2'd0,
    RATE_DIV2 = 2'd1,
    RATE_DIV3 = 2'd2,
    RATE_TWO3 = 2'd3
  } rate_e;

  typedef struct packed {
    logic wrap;
    logic levelHigh;
    logic periodBegin;
  } dpStrobes_t;
endpackage

// File: rtl/pixdiv_ctrl.sv
module pixdiv_ctrl
  import pixdiv_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] cnt,
  input  rate_e            mode,
  output dpStrobes_t       strb
);
  localparam logic [CNT_W-1:0] LAST_DIV1 = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_DIV2 = CNT_W'(3);
  localparam logic [CNT_W-1:0] LAST_DIV3 = CNT_W'(5);
  localparam logic [CNT_W-1:0] LAST_TWO3 = CNT_W'(5);
  localparam logic [CNT_W-1:0] HALF_TWO3 = CNT_W'(3);

  logic [CNT_W-1:0] lastCnt;

  always_comb begin
    unique case (mode)
      RATE_DIV1: lastCnt = LAST_DIV1;
      RATE_DIV2: lastCnt = LAST_DIV2;
      RATE_DIV3: lastCnt = LAST_DIV3;
      default:   lastCnt = LAST_TWO3;
    endcase
  end

  always_comb begin
    strb.wrap = (cnt == lastCnt);
    unique case (mode)
      RATE_DIV1: strb.levelHigh = (cnt == '0);
      RATE_DIV2: strb.levelHigh = (cnt < CNT_W'(2));
      RATE_DIV3: strb.levelHigh = (cnt < CNT_W'(3));
      default:   strb.levelHigh = (cnt == '0) || (cnt == HALF_TWO3);
    endcase
    strb.periodBegin = (cnt == '0) || ((mode == RATE_TWO3) && (cnt == HALF_TWO3));
  end
endmodule

// File: rtl/pixdiv_dp.sv
module pixdiv_dp
  import pixdiv_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             refClk,
  input  logic             rst,
  input  logic [1:0]       rateSel,
  input  dpStrobes_t       strb,
  output logic [CNT_W-1:0] cnt,
  output rate_e            mode,
  output logic             pixClk,
  output logic             periodStart,
  output logic             windowEnd
);
  always_ff @(posedge refClk) begin
    if (rst) begin
      cnt         <= '0;
      mode        <= RATE_DIV1;
      pixClk      <= 1'b0;
      periodStart <= 1'b0;
      windowEnd   <= 1'b0;
    end else begin
      pixClk      <= strb.levelHigh;
      periodStart <= strb.periodBegin;
      windowEnd   <= strb.wrap;
      if (strb.wrap) begin
        cnt  <= '0;
        mode <= rate_e'(rateSel);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // Rate may change only at a window boundary
  assert_mode_hold_R6: assert property (@(posedge refClk) disable iff (rst)
    !strb.wrap |=> $stable(mode));

  assert_start_high_R7: assert property (@(posedge refClk) disable iff (rst)
    periodStart |-> pixClk);

  assert_rise_is_start_R7: assert property (@(posedge refClk) disable iff (rst)
    $rose(pixClk) |-> periodStart);

  assert_end_low_R8: assert property (@(posedge refClk) disable iff (rst)
    windowEnd |-> !pixClk);

  assert_end_then_start_R8: assert property (@(posedge refClk) disable iff (rst)
    windowEnd |=> periodStart);
endmodule

// File: rtl/pixclk_divider.sv
module pixclk_divider
  import pixdiv_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic       refClk,
  input  logic       rst,
  input  logic [1:0] rateSel,
  output logic       pixClk,
  output logic       periodStart,
  output logic       windowEnd
);
  logic [CNT_W-1:0] cnt;
  rate_e            mode;
  dpStrobes_t       strb;

  pixdiv_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .cnt  (cnt),
    .mode (mode),
    .strb (strb)
  );

  pixdiv_dp #(.CNT_W(CNT_W)) i_dp (
    .refClk      (refClk),
    .rst         (rst),
    .rateSel     (rateSel),
    .strb        (strb),
    .cnt         (cnt),
    .mode        (mode),
    .pixClk      (pixClk),
    .periodStart (periodStart),
    .windowEnd   (windowEnd)
  );
endmodule

// File: tb/test_pixclk_divider.sv
`timescale 1ns/1ps
module test_pixclk_divider;
  logic refClk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] rateSel = 2'd0;
  logic pixClk, periodStart, windowEnd;

  int testsRun = 0;
  int testsFail = 0;
  int mCnt = 0;
  int mMode = 0;
  bit done = 1'b0;

  always #4 refClk = ~refClk;

  pixclk_divider i_pixclk_divider (
    .refClk(refClk), .rst(rst), .rateSel(rateSel),
    .pixClk(pixClk), .periodStart(periodStart), .windowEnd(windowEnd)
  );

  function automatic int winLen(input int m);
    case (m)
      0: return 2;
      1: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic bit expLevel(input int m, input int c);
    case (m)
      0: return c == 0;
      1: return c < 2;
      2: return c < 3;
      default: return (c == 0) || (c == 3);
    endcase
  endfunction

  function automatic bit expStart(input int m, input int c);
    return (c == 0) || (m == 3 && c == 3);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s: actual %b expected %b (mode %0d state %0d) at %0t",
               req, act, exp, mMode, mCnt, $time);
    end
  endtask

  // One tick: called right after a falling edge. Checks outputs, advances model.
  task automatic tick(input logic [1:0] nextSel);
    string lvlTag;
    @(negedge refClk);
    case (mMode)
      0: lvlTag = "R2";
      1: lvlTag = "R3";
      2: lvlTag = "R4";
      default: lvlTag = "R5";
    endcase
    if (rateSel != 2'(mMode) && mCnt != winLen(mMode) - 1) lvlTag = {lvlTag, "/R6"};
    check(lvlTag, pixClk, expLevel(mMode, mCnt));
    check("R7", periodStart, expStart(mMode, mCnt));
    check("R8", windowEnd, mCnt == winLen(mMode) - 1);
    if (mCnt == winLen(mMode) - 1) begin
      mCnt = 0;
      mMode = int'(rateSel);
    end else begin
      mCnt++;
    end
    rateSel = nextSel;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge refClk);
    if (!done) begin
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    int toggles;
    logic prev;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    // R1: reset state
    repeat (3) begin
      @(negedge refClk);
      check("R1", pixClk, 1'b0);
      check("R1", periodStart, 1'b0);
      check("R1", windowEnd, 1'b0);
    end
    rateSel = 2'd3;
    rst = 1'b0;
    // First window runs at divide-by-1 (R1), code 11 taken at its end
    for (int i = 0; i < 2; i++) tick(2'd3);
    // R5: directed two-thirds window, count level changes over six ticks
    prev = pixClk;
    toggles = 0;
    for (int i = 0; i < 6; i++) begin
      tick(2'd3);
      if (pixClk !== prev) toggles++;
      prev = pixClk;
    end
    for (int i = 0; i < 6; i++) begin
      tick(2'd3);
      if (pixClk !== prev) toggles++;
      prev = pixClk;
    end
    check("R5 toggles", toggles == 8, 1'b1);
    // Directed holds in each mode
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 24; i++) tick(2'(m));
    // R6: mid-window change in divide-by-3 to divide-by-1
    for (int i = 0; i < 6; i++) tick(2'd2);
    tick(2'd0);
    for (int i = 0; i < 12; i++) tick(2'd0);
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] s;
      s = rateSel;
      if ($urandom_range(0, 3) == 0) s = 2'($urandom_range(0, 3));
      tick(s);
    end
    // Reset again mid-stream: R1
    @(negedge refClk);
    rst = 1'b1;
    @(negedge refClk);
    @(negedge refClk);
    check("R1", pixClk, 1'b0);
    check("R1", windowEnd, 1'b0);
    mCnt = 0;
    mMode = 0;
    rateSel = 2'd1;
    rst = 1'b0;
    for (int i = 0; i < 40; i++) tick(2'd1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule